// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Controller

This block lets a sequential fetch unit repeat a block of instructions a set number of times without any branch instruction. A loop instruction announces itself with a one-cycle start strobe. Along with the strobe it supplies its own address, an unsigned iteration count and the number of instructions in the body. The count comes either from a general register or from a narrower unsigned immediate. The body begins at the instruction right after the loop instruction. From then on the controller compares each fetched address with the last instruction of the innermost active loop. While iterations remain, it asks fetch to jump back to the body start.

Loop contexts are held in a stack of parameterised depth, so loops can nest. When the innermost loop runs out of iterations, its context is discarded and the enclosing loop becomes the one being watched. Two malformed starts are refused and reported with an error pulse: a zero count or zero body, and a start while every stack slot is occupied. Decoding, the register file and ordinary branches belong to the surrounding core.

Top module: `hwloop_ctrl`

## Requirements
- R1: After reset no loop is active: no fetch address produces a redirect and both error outputs are 0.
- R2: An accepted start at address P with body length B gives a body from P+4 to P+4*B inclusive. The loop-back target is P+4.
- R3: When cnt_from_reg_i is 1, the iteration count is the full unsigned reg_cnt_i. When it is 0, the count is imm_cnt_i zero-extended, and reg_cnt_i is ignored.
- R4: When a valid fetch address equals the innermost loop's last body address and more than one iteration remains, redirect_o is 1 in that same cycle and target_o is the body start. The remaining count then drops by one.
- R5: A loop with count N produces exactly N-1 redirects. On its N-th arrival at the last body instruction there is no redirect, and fetch continues past the body.
- R6: A start with a zero count or a zero body length pushes no context. It raises err_bad_arg_o for the one cycle after the strobe.
- R7: A start while DEPTH contexts are active pushes nothing and raises err_full_o for the one cycle after the strobe. Existing contexts are unchanged. The two error outputs are never 1 together; a bad argument takes precedence.
- R8: When the innermost loop completes, its context is removed and the enclosing loop's last-instruction check and remaining count take effect again.
- R9: No redirect occurs when pc_valid_i is 0, or in a cycle where loop_start_i is 1. Such cycles do not change any remaining count.
- R10: target_o is zero whenever redirect_o is 0.
- R11: A count of one runs the body once with no redirect and leaves no context behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pc_valid_i | input | 1 | An instruction is fetched at pc_i this cycle |
| pc_i | input | ADDR_W | Current fetch address; the loop instruction's address while loop_start_i is 1 |
| loop_start_i | input | 1 | One-cycle strobe for a loop instruction |
| cnt_from_reg_i | input | 1 | 1: count from reg_cnt_i, 0: count from imm_cnt_i |
| reg_cnt_i | input | CNT_W | Iteration count read from a general register |
| imm_cnt_i | input | IMM_CNT_W | Iteration count taken from an immediate |
| body_len_i | input | BODY_W | Body length in instructions |
| redirect_o | output | 1 | Fetch must jump to target_o |
| target_o | output | ADDR_W | Body start of the innermost loop while redirecting, else zero |
| err_bad_arg_o | output | 1 | Pulse: start refused for zero count or zero body |
| err_full_o | output | 1 | Pulse: start refused because the stack is full |

## Verification
Loops are walked instruction by instruction with several kinds of count. Register counts of four and of 1025 are used; the second does not fit the immediate field, so a truncated count would show up as one iteration. Immediate counts of two and one are used while the register input holds a large unrelated value, which exposes a wrong source select or an off-by-one exit. A two-level nest with a loop instruction inside the outer body shows whether the outer context survives the inner one's push and removal. Filling every slot and then unwinding all of them shows whether an overflowing start corrupts stored contexts. A held-off fetch and a refused start placed exactly on a last-body address show that those cycles neither redirect nor consume an iteration.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;

    // Operation applied to the loop-context stack in one cycle
    typedef enum logic [1:0] {
        STK_HOLD = 2'd0,
        STK_PUSH = 2'd1,
        STK_DEC  = 2'd2,
        STK_POP  = 2'd3
    } stk_op_e;

    // Byte distance between consecutive instructions
    localparam int unsigned INSN_BYTES = 4;
    localparam int unsigned INSN_SHIFT = 2;

endpackage

// File: rtl/hwloop_ctx_stack.sv
module hwloop_ctx_stack
    import hwloop_pkg::*;
#(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CNT_W  = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  stk_op_e           op_i,
    input  logic [ADDR_W-1:0] push_start_i,
    input  logic [ADDR_W-1:0] push_last_i,
    input  logic [CNT_W-1:0]  push_cnt_i,
    output logic              top_valid_o,
    output logic [ADDR_W-1:0] top_start_o,
    output logic [ADDR_W-1:0] top_last_o,
    output logic [CNT_W-1:0]  top_cnt_o,
    output logic              full_o
);

    localparam int unsigned PTR_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [ADDR_W-1:0] start;
        logic [ADDR_W-1:0] last;
        logic [CNT_W-1:0]  cnt;
    } ctx_t;

    logic [PTR_W-1:0] ptr_d, ptr_q;
    ctx_t             ctx_all [DEPTH];
    ctx_t             top_ctx;

    // Occupancy pointer: number of live contexts
    always_comb begin
        ptr_d = ptr_q;
        case (op_i)
            STK_PUSH: ptr_d = ptr_q + PTR_W'(1);
            STK_POP:  ptr_d = ptr_q - PTR_W'(1);
            default:  ptr_d = ptr_q;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    // One register per slot; a slot is written on push into it or on
    // decrement while it is the top
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
        ctx_t ent_d, ent_q;

        always_comb begin
            ent_d = ent_q;
            if (op_i == STK_PUSH && ptr_q == PTR_W'(gi)) begin
                ent_d.start = push_start_i;
                ent_d.last  = push_last_i;
                ent_d.cnt   = push_cnt_i;
            end else if (op_i == STK_DEC && ptr_q == PTR_W'(gi + 1)) begin
                ent_d.cnt = ent_q.cnt - CNT_W'(1);
            end
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                ent_q <= '0;
            end else begin
                ent_q <= ent_d;
            end
        end

        assign ctx_all[gi] = ent_q;
    end

    // Select the innermost live context
    always_comb begin
        top_ctx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (ptr_q == PTR_W'(i + 1)) begin
                top_ctx = ctx_all[i];
            end
        end
    end

    assign top_valid_o = (ptr_q != '0);
    assign full_o      = (ptr_q == PTR_W'(DEPTH));
    assign top_start_o = top_ctx.start;
    assign top_last_o  = top_ctx.last;
    assign top_cnt_o   = top_ctx.cnt;

endmodule

// File: rtl/hwloop_end_match.sv
module hwloop_end_match #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CNT_W  = 32
) (
    input  logic              pc_valid_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic              suppress_i,
    input  logic              top_valid_i,
    input  logic [ADDR_W-1:0] top_last_i,
    input  logic [CNT_W-1:0]  top_cnt_i,
    output logic              loop_back_o,
    output logic              finish_o
);

    logic hit;
    logic more_left;

    assign hit         = pc_valid_i && !suppress_i && top_valid_i && (pc_i == top_last_i);
    assign more_left   = (top_cnt_i > CNT_W'(1));
    assign loop_back_o = hit && more_left;
    assign finish_o    = hit && !more_left;

endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl
    import hwloop_pkg::*;
#(
    parameter int unsigned DEPTH     = 8,
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned CNT_W     = 32,
    parameter int unsigned IMM_CNT_W = 10,
    parameter int unsigned BODY_W    = 12
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 pc_valid_i,
    input  logic [ADDR_W-1:0]    pc_i,
    input  logic                 loop_start_i,
    input  logic                 cnt_from_reg_i,
    input  logic [CNT_W-1:0]     reg_cnt_i,
    input  logic [IMM_CNT_W-1:0] imm_cnt_i,
    input  logic [BODY_W-1:0]    body_len_i,
    output logic                 redirect_o,
    output logic [ADDR_W-1:0]    target_o,
    output logic                 err_bad_arg_o,
    output logic                 err_full_o
);

    typedef struct packed {
        logic bad_arg;
        logic full;
    } err_t;

    err_t              err_d, err_q;
    stk_op_e           op;
    logic [CNT_W-1:0]  cnt_sel;
    logic [ADDR_W-1:0] body_start;
    logic [ADDR_W-1:0] body_last;
    logic              arg_bad;
    logic              start_ok;
    logic              top_valid;
    logic [ADDR_W-1:0] top_start;
    logic [ADDR_W-1:0] top_last;
    logic [CNT_W-1:0]  top_cnt;
    logic              stk_full;
    logic              loop_back;
    logic              finish;

    // Decide the stack operation and the error flags for the next cycle
    always_comb begin
        cnt_sel    = cnt_from_reg_i ? reg_cnt_i : CNT_W'(imm_cnt_i);
        body_start = pc_i + ADDR_W'(INSN_BYTES);
        body_last  = pc_i + (ADDR_W'(body_len_i) << INSN_SHIFT);
        arg_bad    = (cnt_sel == '0) || (body_len_i == '0);
        start_ok   = loop_start_i && !arg_bad && !stk_full;

        err_d         = '0;
        err_d.bad_arg = loop_start_i && arg_bad;
        err_d.full    = loop_start_i && !arg_bad && stk_full;

        if (start_ok) begin
            op = STK_PUSH;
        end else if (loop_back) begin
            op = STK_DEC;
        end else if (finish) begin
            op = STK_POP;
        end else begin
            op = STK_HOLD;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            err_q <= '0;
        end else begin
            err_q <= err_d;
        end
    end

    hwloop_ctx_stack #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_stack (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .op_i         (op),
        .push_start_i (body_start),
        .push_last_i  (body_last),
        .push_cnt_i   (cnt_sel),
        .top_valid_o  (top_valid),
        .top_start_o  (top_start),
        .top_last_o   (top_last),
        .top_cnt_o    (top_cnt),
        .full_o       (stk_full)
    );

    hwloop_end_match #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_match (
        .pc_valid_i  (pc_valid_i),
        .pc_i        (pc_i),
        .suppress_i  (loop_start_i),
        .top_valid_i (top_valid),
        .top_last_i  (top_last),
        .top_cnt_i   (top_cnt),
        .loop_back_o (loop_back),
        .finish_o    (finish)
    );

    assign redirect_o    = loop_back;
    assign target_o      = loop_back ? top_start : '0;
    assign err_bad_arg_o = err_q.bad_arg;
    assign err_full_o    = err_q.full;

endmodule

// File: rtl/hwloop_ctrl_checker.sv
module hwloop_ctrl_checker #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned BODY_W = 12
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              pc_valid_i,
    input logic              loop_start_i,
    input logic [BODY_W-1:0] body_len_i,
    input logic              redirect_o,
    input logic [ADDR_W-1:0] target_o,
    input logic              err_bad_arg_o,
    input logic              err_full_o
);

    p_target_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !redirect_o |-> target_o == '0);

    p_no_redirect_on_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        loop_start_i |-> !redirect_o);

    p_needs_fetch_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pc_valid_i |-> !redirect_o);

    p_empty_body_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (loop_start_i && body_len_i == '0) |=> err_bad_arg_o);

    p_full_needs_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_full_o |-> $past(loop_start_i));

    p_err_exclusive_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(err_bad_arg_o && err_full_o));

endmodule

bind hwloop_ctrl hwloop_ctrl_checker #(
    .ADDR_W (ADDR_W),
    .BODY_W (BODY_W)
) u_checker (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .pc_valid_i    (pc_valid_i),
    .loop_start_i  (loop_start_i),
    .body_len_i    (body_len_i),
    .redirect_o    (redirect_o),
    .target_o      (target_o),
    .err_bad_arg_o (err_bad_arg_o),
    .err_full_o    (err_full_o)
);

// File: tb/hwloop_ctrl_tb_top.sv
module hwloop_ctrl_tb_top;

    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned DEPTH      = 8;
    localparam int unsigned ADDR_W     = 32;
    localparam int unsigned CNT_W      = 32;
    localparam int unsigned IMM_CNT_W  = 10;
    localparam int unsigned BODY_W     = 12;
    localparam int unsigned WATCHDOG   = 150000;

    logic                 clk_i = 1'b0;
    logic                 rst_ni = 1'b0;
    logic                 pc_valid_i = 1'b0;
    logic [ADDR_W-1:0]    pc_i = '0;
    logic                 loop_start_i = 1'b0;
    logic                 cnt_from_reg_i = 1'b0;
    logic [CNT_W-1:0]     reg_cnt_i = '0;
    logic [IMM_CNT_W-1:0] imm_cnt_i = '0;
    logic [BODY_W-1:0]    body_len_i = '0;
    logic                 redirect_o;
    logic [ADDR_W-1:0]    target_o;
    logic                 err_bad_arg_o;
    logic                 err_full_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit finished = 1'b0;

    hwloop_ctrl #(
        .DEPTH     (DEPTH),
        .ADDR_W    (ADDR_W),
        .CNT_W     (CNT_W),
        .IMM_CNT_W (IMM_CNT_W),
        .BODY_W    (BODY_W)
    ) dut_i (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .pc_valid_i     (pc_valid_i),
        .pc_i           (pc_i),
        .loop_start_i   (loop_start_i),
        .cnt_from_reg_i (cnt_from_reg_i),
        .reg_cnt_i      (reg_cnt_i),
        .imm_cnt_i      (imm_cnt_i),
        .body_len_i     (body_len_i),
        .redirect_o     (redirect_o),
        .target_o       (target_o),
        .err_bad_arg_o  (err_bad_arg_o),
        .err_full_o     (err_full_o)
    );

    always #(CLK_PERIOD / 2) clk_i = ~clk_i;

    task automatic check(input logic [63:0] act, input logic [63:0] exp,
                         input string req, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // One fetch cycle; redirect/target are combinational, checked before the edge
    task automatic fetch(input logic [ADDR_W-1:0] pc, input logic v,
                         input logic exp_r, input logic [ADDR_W-1:0] exp_t,
                         input string req);
        @(negedge clk_i);
        loop_start_i = 1'b0;
        pc_valid_i   = v;
        pc_i         = pc;
        #1;
        check(64'(redirect_o), 64'(exp_r), req, "redirect");
        check(64'(target_o), 64'(exp_t), req, "target");
        @(posedge clk_i);
    endtask

    // Loop instruction strobe, then check the error pulses one cycle later
    task automatic start_loop(input logic [ADDR_W-1:0] pc, input logic from_reg,
                              input logic [CNT_W-1:0] rc, input logic [IMM_CNT_W-1:0] ic,
                              input logic [BODY_W-1:0] body,
                              input logic exp_bad, input logic exp_full,
                              input string req);
        @(negedge clk_i);
        pc_valid_i     = 1'b1;
        pc_i           = pc;
        loop_start_i   = 1'b1;
        cnt_from_reg_i = from_reg;
        reg_cnt_i      = rc;
        imm_cnt_i      = ic;
        body_len_i     = body;
        #1;
        check(64'(redirect_o), 64'd0, "R9", "redirect during start");
        @(posedge clk_i);
        @(negedge clk_i);
        loop_start_i = 1'b0;
        pc_valid_i   = 1'b0;
        #1;
        check(64'(err_bad_arg_o), 64'(exp_bad), req, "err_bad_arg");
        check(64'(err_full_o), 64'(exp_full), req, "err_full");
    endtask

    // Walk a loop whose instruction sits at base: count passes then fall through
    task automatic run_body(input logic [ADDR_W-1:0] base, input int body,
                            input int count, input string req);
        for (int it = 0; it < count; it++) begin
            for (int k = 1; k <= body; k++) begin
                logic last_insn;
                logic exp_r;
                last_insn = (k == body);
                exp_r     = last_insn && (it < count - 1);
                fetch(base + ADDR_W'(4 * k), 1'b1, exp_r, exp_r ? base + 32'd4 : '0, req);
            end
        end
        fetch(base + ADDR_W'(4 * body + 4), 1'b1, 1'b0, '0, req);
    endtask

    task automatic t_reset;
        fetch(32'h0000_0004, 1'b1, 1'b0, '0, "R1");
        check(64'(err_bad_arg_o), 64'd0, "R1", "err_bad_arg after reset");
        check(64'(err_full_o), 64'd0, "R1", "err_full after reset");
    endtask

    // R2 R3 R4 R5: register count 4, body 3
    task automatic t_reg_loop;
        start_loop(32'h0000_0100, 1'b1, 32'd4, 10'd0, 12'd3, 1'b0, 1'b0, "R3");
        run_body(32'h0000_0100, 3, 4, "R4");
    endtask

    // R3: immediate count used, register value ignored; R11 single pass
    task automatic t_imm_loop;
        start_loop(32'h0000_0200, 1'b0, 32'd77, 10'd2, 12'd1, 1'b0, 1'b0, "R3");
        run_body(32'h0000_0200, 1, 2, "R3");
        start_loop(32'h0000_0240, 1'b0, 32'd50, 10'd1, 12'd2, 1'b0, 1'b0, "R11");
        run_body(32'h0000_0240, 2, 1, "R11");
        // no context left: the same last address must not redirect
        fetch(32'h0000_0248, 1'b1, 1'b0, '0, "R11");
    endtask

    // R3 R5: register count wider than the immediate field
    task automatic t_reg_wide;
        start_loop(32'h0000_0400, 1'b1, 32'd1025, 10'd0, 12'd1, 1'b0, 1'b0, "R3");
        run_body(32'h0000_0400, 1, 1025, "R5");
    endtask

    // R6: zero count and zero body refused
    task automatic t_bad_args;
        start_loop(32'h0000_0500, 1'b1, 32'd0, 10'd5, 12'd2, 1'b1, 1'b0, "R6");
        fetch(32'h0000_0508, 1'b1, 1'b0, '0, "R6");
        start_loop(32'h0000_0500, 1'b0, 32'd9, 10'd0, 12'd2, 1'b1, 1'b0, "R6");
        fetch(32'h0000_0508, 1'b1, 1'b0, '0, "R6");
        start_loop(32'h0000_0500, 1'b1, 32'd3, 10'd0, 12'd0, 1'b1, 1'b0, "R6");
        fetch(32'h0000_0500, 1'b1, 1'b0, '0, "R6");
    endtask

    // R8: outer (count 2, body 4) with an inner loop (count 3, body 2)
    task automatic t_nest;
        start_loop(32'h0000_0600, 1'b0, 32'd0, 10'd2, 12'd4, 1'b0, 1'b0, "R8");
        for (int pass = 0; pass < 2; pass++) begin
            start_loop(32'h0000_0604, 1'b1, 32'd3, 10'd0, 12'd2, 1'b0, 1'b0, "R8");
            for (int it = 0; it < 3; it++) begin
                fetch(32'h0000_0608, 1'b1, 1'b0, '0, "R8");
                fetch(32'h0000_060C, 1'b1, it < 2, it < 2 ? 32'h0000_0608 : '0, "R8");
            end
            fetch(32'h0000_0610, 1'b1, pass == 0, pass == 0 ? 32'h0000_0604 : '0, "R8");
        end
        fetch(32'h0000_0614, 1'b1, 1'b0, '0, "R8");
    endtask

    // R7: fill all slots, overflow, then unwind each one intact
    task automatic t_full;
        for (int i = 0; i < DEPTH; i++) begin
            start_loop(32'h0000_1000 + ADDR_W'(i * 32'h100), 1'b0, 32'd0, 10'd2, 12'd1,
                       1'b0, 1'b0, "R7");
        end
        start_loop(32'h0000_3000, 1'b0, 32'd0, 10'd2, 12'd1, 1'b0, 1'b1, "R7");
        fetch(32'h0000_3004, 1'b1, 1'b0, '0, "R7");
        // zero count while full reports the bad argument only
        start_loop(32'h0000_3000, 1'b1, 32'd0, 10'd0, 12'd1, 1'b1, 1'b0, "R7");
        for (int i = DEPTH - 1; i >= 0; i--) begin
            logic [ADDR_W-1:0] b;
            b = 32'h0000_1000 + ADDR_W'(i * 32'h100);
            fetch(b + 32'd4, 1'b1, 1'b1, b + 32'd4, "R7");
            fetch(b + 32'd4, 1'b1, 1'b0, '0, "R7");
        end
    endtask

    // R9 R10: held-off fetch and a refused start on the last address
    task automatic t_gating;
        start_loop(32'h0000_0700, 1'b0, 32'd0, 10'd2, 12'd1, 1'b0, 1'b0, "R9");
        fetch(32'h0000_0704, 1'b0, 1'b0, '0, "R9");
        start_loop(32'h0000_0704, 1'b1, 32'd0, 10'd0, 12'd1, 1'b1, 1'b0, "R9");
        fetch(32'h0000_0704, 1'b1, 1'b1, 32'h0000_0704, "R9");
        fetch(32'h0000_0704, 1'b1, 1'b0, '0, "R10");
        fetch(32'h0000_0704, 1'b1, 1'b0, '0, "R10");
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    always @(posedge clk_i) begin
        cycles++;
        if (cycles > WATCHDOG && !finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=%0d cycles expected=<%0d", cycles, WATCHDOG);
            summary();
        end
    end

    initial begin
        repeat (3) @(posedge clk_i);
        @(negedge clk_i);
        rst_ni = 1'b1;
        t_reset();
        t_reg_loop();
        t_imm_loop();
        t_reg_wide();
        t_bad_args();
        t_nest();
        t_full();
        t_gating();
        summary();
    end

endmodule